// File: doc/BRIEF.md
# Infrared Carrier Edge-Window Demodulator

This block turns a carrier-modulated infrared input into a baseband mark/space envelope. A programmable divider slices the reference clock into receive ticks. The block counts ticks between successive rising edges of the already-synchronized infrared input. It accepts an edge as carrier only when that count lands inside a tolerance window around a nominal period of 16 ticks. The window's lower and upper margins are chosen independently by a 2-bit code.

Two back-to-back in-window intervals raise the envelope to mark. The envelope falls back to space once no in-window edge has been seen for longer than the window's upper bound. With demodulation switched off, the raw input level is handed through as the envelope. Dropping the enable parks the block at space and forgets all carrier history. Pulse-width timing, buffering and register access sit in neighbouring blocks.

Top module: `ir_carrier_demod`

## Requirements
- R1: With divider value D, one receive tick occurs every D+1 reference clocks. Edge intervals are counted in ticks: the ticks in the clock cycles after one rising edge, up to and including the cycle of the next.
- R2: An interval is in-window when 16-L <= ticks <= 16+H, both bounds inclusive. L is 4 when bit 0 of the window code is 1 and 3 otherwise. H is 4 when bit 1 is 1 and 3 otherwise. Codes 0, 1, 2 and 3 therefore give -3/+3, -4/+3, -3/+4 and -4/+4.
- R3: In demodulation mode, the envelope goes to mark (1) one clock after the second consecutive in-window interval closes. An out-of-window interval restarts the count of consecutive in-window intervals.
- R4: The envelope returns to space (0) once more than 16+H ticks have elapsed since the last in-window edge. An edge arriving exactly 16+H ticks after the previous one keeps mark.
- R5: Only rising edges of the input delimit intervals. The position of falling edges has no effect.
- R6: With enable high and demodulation off, the envelope equals the input one clock later.
- R7: With enable low, the envelope is space one clock later and all interval history is cleared. After enable returns, the first rising edge starts a new measurement and is not judged.
- R8: After reset the envelope is space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low forces space and clears history |
| demod_en | input | 1 | 1 = carrier demodulation, 0 = pass the input through |
| ir_in | input | 1 | Synchronized infrared input level |
| div_val | input | DIV_W | Tick divider; one tick per div_val+1 clocks |
| win_sel | input | 2 | Tolerance code; bit 0 widens the lower margin, bit 1 widens the upper margin |
| envelope | output | 1 | Demodulated level, 1 = mark |

## Verification
Rising-edge trains are driven at periods of 12, 13, 16, 19 and 20 ticks under every window code. This separates the inclusive bounds from the exclusive ones and shows which code bit widens which side. A train broken by one short interval shows that a single good interval is not enough. Trains with irregular pulse widths but fixed rising-edge spacing show that falling edges are ignored. The same clock-cycle period is run with divider values 0 and 2, which shows that intervals are counted in divided ticks rather than in clocks. The exact cycle where the envelope drops after the last edge pins the timeout to 16+H ticks.

// File: rtl/ir_demod_pkg.sv
package ir_demod_pkg;

  // nominal carrier period in receive ticks
  localparam int unsigned NOM_TICKS = 16;

  // tolerance below the nominal period, in ticks
  function automatic logic [2:0] win_low(input logic [1:0] sel);
    return sel[0] ? 3'd4 : 3'd3;
  endfunction

  // tolerance above the nominal period, in ticks
  function automatic logic [2:0] win_high(input logic [1:0] sel);
    return sel[1] ? 3'd4 : 3'd3;
  endfunction

endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  // one registered pulse every div_i+1 clocks
  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
      tick_o <= 1'b0;
    end
  end

endmodule

// File: rtl/ir_edge_meas.sv
module ir_edge_meas #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             ir_i,
  input  logic             tick_i,
  output logic             rise_o,
  output logic             have_prev_o,
  output logic [CNT_W-1:0] meas_o
);

  localparam logic [CNT_W-1:0] SAT_V = '1;

  logic             ir_q;
  logic [CNT_W-1:0] gap_q;

  assign rise_o = en_i && ir_i && !ir_q;

  // ticks since the last rising edge, including this cycle's tick
  assign meas_o = (gap_q == SAT_V) ? gap_q : gap_q + CNT_W'(tick_i);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      ir_q        <= 1'b0;
      gap_q       <= '0;
      have_prev_o <= 1'b0;
    end else begin
      ir_q <= ir_i;
      if (rise_o) begin
        gap_q       <= '0;
        have_prev_o <= 1'b1;
      end else begin
        gap_q <= meas_o;
      end
    end
  end

endmodule

// File: rtl/ir_window_chk.sv
module ir_window_chk #(
  parameter int CNT_W = 6
) (
  input  logic [1:0]       win_sel_i,
  input  logic             rise_i,
  input  logic             have_prev_i,
  input  logic [CNT_W-1:0] meas_i,
  output logic             good_o,
  output logic             bad_o,
  output logic [CNT_W-1:0] hi_lim_o
);
  import ir_demod_pkg::*;

  localparam logic [CNT_W-1:0] NOM = CNT_W'(NOM_TICKS);

  logic [CNT_W-1:0] lo_lim;
  logic             judged;
  logic             in_win;

  assign lo_lim   = NOM - CNT_W'(win_low(win_sel_i));
  assign hi_lim_o = NOM + CNT_W'(win_high(win_sel_i));
  assign judged   = rise_i && have_prev_i;
  assign in_win   = (meas_i >= lo_lim) && (meas_i <= hi_lim_o);
  assign good_o   = judged && in_win;
  assign bad_o    = judged && !in_win;

endmodule

// File: rtl/ir_envelope.sv
module ir_envelope #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             demod_i,
  input  logic             ir_i,
  input  logic             tick_i,
  input  logic             good_i,
  input  logic             bad_i,
  input  logic [CNT_W-1:0] hi_lim_i,
  output logic             env_o
);

  localparam logic [CNT_W-1:0] SAT_V = '1;

  logic             streak_q;
  logic [CNT_W-1:0] quiet_q;
  logic [CNT_W-1:0] quiet_nx;

  assign quiet_nx = (quiet_q == SAT_V) ? quiet_q : quiet_q + CNT_W'(tick_i);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      env_o    <= 1'b0;
      streak_q <= 1'b0;
      quiet_q  <= '0;
    end else if (!demod_i) begin
      env_o    <= ir_i;
      streak_q <= 1'b0;
      quiet_q  <= '0;
    end else if (good_i) begin
      quiet_q  <= '0;
      streak_q <= 1'b1;
      if (streak_q) env_o <= 1'b1;
    end else begin
      quiet_q <= quiet_nx;
      if (bad_i) streak_q <= 1'b0;
      if (quiet_nx > hi_lim_i) begin
        env_o    <= 1'b0;
        streak_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ir_carrier_demod.sv
module ir_carrier_demod #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             demod_en,
  input  logic             ir_in,
  input  logic [DIV_W-1:0] div_val,
  input  logic [1:0]       win_sel,
  output logic             envelope
);

  logic             rx_tick;
  logic             rise;
  logic             have_prev;
  logic [CNT_W-1:0] meas;
  logic             valid_edge;
  logic             bad_edge;
  logic [CNT_W-1:0] hi_lim;

  ir_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .en_i  (rx_en),
    .div_i (div_val),
    .tick_o(rx_tick)
  );

  ir_edge_meas #(.CNT_W(CNT_W)) u_meas (
    .clk        (clk),
    .rst        (rst),
    .en_i       (rx_en),
    .ir_i       (ir_in),
    .tick_i     (rx_tick),
    .rise_o     (rise),
    .have_prev_o(have_prev),
    .meas_o     (meas)
  );

  ir_window_chk #(.CNT_W(CNT_W)) u_win (
    .win_sel_i  (win_sel),
    .rise_i     (rise),
    .have_prev_i(have_prev),
    .meas_i     (meas),
    .good_o     (valid_edge),
    .bad_o      (bad_edge),
    .hi_lim_o   (hi_lim)
  );

  ir_envelope #(.CNT_W(CNT_W)) u_env (
    .clk     (clk),
    .rst     (rst),
    .en_i    (rx_en),
    .demod_i (demod_en),
    .ir_i    (ir_in),
    .tick_i  (rx_tick),
    .good_i  (valid_edge),
    .bad_i   (bad_edge),
    .hi_lim_i(hi_lim),
    .env_o   (envelope)
  );

endmodule

// File: rtl/ir_demod_chk.sv
module ir_demod_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_en,
  input logic             demod_en,
  input logic             ir_in,
  input logic [DIV_W-1:0] div_val,
  input logic             envelope,
  input logic             rx_tick,
  input logic             valid_edge
);

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (rx_en && rx_tick && div_val != '0) |=> (!rx_tick || div_val != $past(div_val)));

  p_mark_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(envelope) && $past(rx_en) && $past(demod_en)) |-> $past(valid_edge));

  p_space_on_timeout_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(envelope) && $past(rx_en) && $past(demod_en)) |-> !$past(valid_edge));

  p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_en && !demod_en) |=> (envelope == $past(ir_in)));

  p_off_space_r7: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !envelope);

endmodule

bind ir_carrier_demod ir_demod_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .demod_en  (demod_en),
  .ir_in     (ir_in),
  .div_val   (div_val),
  .envelope  (envelope),
  .rx_tick   (rx_tick),
  .valid_edge(valid_edge)
);

// File: tb/tb_ir_carrier_demod.sv
module tb_ir_carrier_demod;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_en;
  logic        demod_en;
  logic        ir_in;
  logic [15:0] div_val;
  logic [1:0]  win_sel;
  logic        envelope;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ir_carrier_demod dut (
    .clk     (clk),
    .rst     (rst),
    .rx_en   (rx_en),
    .demod_en(demod_en),
    .ir_in   (ir_in),
    .div_val (div_val),
    .win_sel (win_sel),
    .envelope(envelope)
  );

  task automatic chk(input string tag, input logic exp);
    checks++;
    if (envelope !== exp) begin
      fails++;
      $display("FAIL %s: envelope=%0b expected=%0b", tag, envelope, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one rising edge, high for w clocks; next call rises p clocks later
  task automatic pulse(input int p, input int w = 2);
    @(negedge clk) ir_in = 1'b1;
    wait_n(w);
    ir_in = 1'b0;
    wait_n(p - w - 1);
  endtask

  task automatic restart(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    ir_in = 1'b0;
    rx_en = 1'b0;
    wait_n(2);
    win_sel  = sel;
    div_val  = d;
    demod_en = 1'b1;
    rx_en    = 1'b1;
    wait_n(2);
  endtask

  task automatic train(input logic [1:0] sel, input logic [15:0] d,
                       input int p, input logic exp, input string tag);
    restart(sel, d);
    for (int i = 0; i < 4; i++) pulse(p);
    chk(tag, exp);
  endtask

  task automatic t_reset;
    chk("R8 envelope during reset", 1'b0);
    @(negedge clk) rst = 1'b0;
    wait_n(2);
    chk("R8 envelope after reset", 1'b0);
  endtask

  task automatic t_basic_and_timeout;
    restart(2'd0, 16'd0);
    pulse(16);
    pulse(16);
    chk("R3 one good interval stays space", 1'b0);
    pulse(16);
    chk("R3 two good intervals give mark", 1'b1);
    wait_n(5);
    chk("R4 mark held up to 16+H ticks", 1'b1);
    wait_n(1);
    chk("R4 space after 16+H+1 ticks", 1'b0);
  endtask

  task automatic t_timeout_wide;
    restart(2'd2, 16'd0);
    for (int i = 0; i < 3; i++) pulse(16);
    chk("R4 mark with H=4", 1'b1);
    wait_n(6);
    chk("R4 mark held at 20 ticks with H=4", 1'b1);
    wait_n(1);
    chk("R4 space at 21 ticks with H=4", 1'b0);
  endtask

  task automatic t_windows;
    train(2'd0, 16'd0, 13, 1'b1, "R2 code0 13 ticks in window");
    train(2'd0, 16'd0, 12, 1'b0, "R2 code0 12 ticks rejected");
    train(2'd0, 16'd0, 19, 1'b1, "R2 R4 code0 19 ticks kept");
    train(2'd0, 16'd0, 20, 1'b0, "R2 code0 20 ticks rejected");
    train(2'd1, 16'd0, 12, 1'b1, "R2 code1 12 ticks in window");
    train(2'd1, 16'd0, 20, 1'b0, "R2 code1 20 ticks rejected");
    train(2'd2, 16'd0, 12, 1'b0, "R2 code2 12 ticks rejected");
    train(2'd2, 16'd0, 20, 1'b1, "R2 code2 20 ticks in window");
    train(2'd3, 16'd0, 12, 1'b1, "R2 code3 12 ticks in window");
    train(2'd3, 16'd0, 20, 1'b1, "R2 code3 20 ticks in window");
    train(2'd3, 16'd0, 11, 1'b0, "R2 code3 11 ticks rejected");
  endtask

  task automatic t_broken_streak;
    restart(2'd0, 16'd0);
    pulse(16);
    pulse(8);
    pulse(16);
    pulse(16);
    chk("R3 short interval restarts streak", 1'b0);
    pulse(16);
    chk("R3 mark after two fresh good intervals", 1'b1);
  endtask

  task automatic t_rise_only;
    restart(2'd0, 16'd0);
    pulse(16, 2);
    pulse(16, 12);
    pulse(16, 5);
    pulse(16, 9);
    chk("R5 falling edge position ignored", 1'b1);
  endtask

  task automatic t_divider;
    train(2'd0, 16'd2, 48, 1'b1, "R1 D=2 48 clocks is 16 ticks");
    train(2'd0, 16'd2, 16, 1'b0, "R1 D=2 16 clocks is too short");
    train(2'd0, 16'd2, 39, 1'b1, "R1 D=2 39 clocks is 13 ticks");
    train(2'd0, 16'd2, 36, 1'b0, "R1 D=2 36 clocks is 12 ticks");
  endtask

  task automatic t_bypass;
    restart(2'd0, 16'd0);
    demod_en = 1'b0;
    @(negedge clk) ir_in = 1'b1;
    @(negedge clk) chk("R6 bypass follows high", 1'b1);
    ir_in = 1'b0;
    @(negedge clk) chk("R6 bypass follows low", 1'b0);
    ir_in = 1'b1;
    @(negedge clk) chk("R6 bypass follows high again", 1'b1);
    ir_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disable;
    restart(2'd0, 16'd0);
    for (int i = 0; i < 3; i++) pulse(16);
    chk("R7 mark before disable", 1'b1);
    @(negedge clk) rx_en = 1'b0;
    @(negedge clk) chk("R7 disable forces space", 1'b0);
    demod_en = 1'b0;
    ir_in = 1'b1;
    wait_n(2);
    chk("R7 disabled bypass stays space", 1'b0);
    ir_in = 1'b0;
    demod_en = 1'b1;
    wait_n(2);
    rx_en = 1'b1;
    pulse(16);
    pulse(16);
    chk("R7 history cleared after re-enable", 1'b0);
    pulse(16);
    chk("R7 mark again after fresh train", 1'b1);
  endtask

  initial begin
    rst = 1'b1;
    rx_en = 1'b0;
    demod_en = 1'b0;
    ir_in = 1'b0;
    div_val = 16'd0;
    win_sel = 2'd0;
    wait_n(3);
    t_reset();
    t_basic_and_timeout();
    t_timeout_wide();
    t_windows();
    t_broken_streak();
    t_rise_only();
    t_divider();
    t_bypass();
    t_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule